// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block keeps the replacement bookkeeping for every set of an N-way set-associative cache and names the way to evict when asked. Three rules are available: pseudo-random choice, evict the way used least often, and evict the way touched longest ago. The rule is picked by a configuration input that the surrounding cache holds steady during normal work. The use counts and recency marks are always kept up to date whatever the rule, so changing the rule takes effect on the next request.

The cache controller pulses `touch_en` with a set and way on every hit or fill, pulses `drop_en` with a set and way when a line is invalidated or evicted, and pulses `ask_en` with a set when it needs a victim. The chosen way appears on `victim_way` one clock later, flagged by `victim_vld`. Tag and data storage live elsewhere.

Top module: `repl_victim_sel`

## Requirements
- R1: After reset every use count and recency mark is zero, the recency clock is zero, `victim_vld` is low and `victim_way` is 0.
- R2: `victim_vld` is high in exactly the cycle after an edge with `ask_en` high and low otherwise; `victim_way` changes only on such an edge and holds its value until the next request.
- R3: Each `touch_en` edge adds one to the use count of that (set, way); with `policy_sel` = 2'b01 the victim is the way whose count is smallest.
- R4: A use count stops at its maximum value 2**CNT_W-1 and never wraps to zero.
- R5: A recency clock counts `touch_en` edges; each touch stores the clock's new value as that way's mark, and with `policy_sel` = 2'b10 the victim is the way with the smallest mark.
- R6: When several ways share the smallest value, the lowest way index wins.
- R7: A 16-bit shift register with feedback x^16+x^14+x^13+x^11+1 (shifted left, new bit = bits 15^13^12^10) starts at 16'hACE1 at reset and steps on every clock edge; with `policy_sel` = 2'b00 or 2'b11 the victim is its value at the request edge modulo NUM_WAYS, and the register is never zero.
- R8: A `drop_en` edge clears both the use count and the recency mark of that (set, way); when a touch and a drop name the same pair in one edge, the drop wins.
- R9: Counts and marks are updated under every policy, so a request after a policy change uses history gathered under the earlier one.
- R10: Each set keeps its own state; activity in one set never changes the victim of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_sel | input | 2 | 00 random, 01 least-used, 10 oldest, 11 random |
| touch_en | input | 1 | Access strobe |
| touch_set | input | SET_W | Set of the access |
| touch_way | input | WAY_W | Way of the access |
| drop_en | input | 1 | Invalidate strobe |
| drop_set | input | SET_W | Set of the invalidated line |
| drop_way | input | WAY_W | Way of the invalidated line |
| ask_en | input | 1 | Victim request strobe |
| ask_set | input | SET_W | Set for which a victim is wanted |
| victim_vld | output | 1 | Victim result valid, one cycle after the request |
| victim_way | output | WAY_W | Selected victim way |

## Verification
The embedded properties watch, on every cycle, the request-to-result timing, the holding of the result between requests, the saturation of use counts, the clearing on invalidate, the fresh mark on a touch and the non-zero state of the random source. Whether the chosen way is truly the minimum with ties going low, whether sets stay independent and whether the random choice follows the stated sequence can only be shown by the bench's sweeps, which rebuild counts, marks and the shift sequence arithmetically and compare each result for every set and every target way.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    typedef enum logic [1:0] {
        POL_RAND = 2'b00,
        POL_LFU  = 2'b01,
        POL_LRU  = 2'b10,
        POL_ALT  = 2'b11
    } policy_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/rvs_lfsr.sv
module rvs_lfsr #(
    parameter logic [15:0] SEED = rvs_pkg::LFSR_SEED
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] value
);

    logic [15:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0000); // R7

endmodule

// File: rtl/rvs_state.sv
module rvs_state #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    parameter int STAMP_W  = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          touch_en,
    input  logic [SET_W-1:0]                              touch_set,
    input  logic [WAY_W-1:0]                              touch_way,
    input  logic                                          drop_en,
    input  logic [SET_W-1:0]                              drop_set,
    input  logic [WAY_W-1:0]                              drop_way,
    output logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0]   cnt_all,
    output logic [NUM_SETS-1:0][NUM_WAYS-1:0][STAMP_W-1:0] stamp_all
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0]   cnt;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][STAMP_W-1:0] stamp;
        logic [STAMP_W-1:0]                             clock;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (touch_en) begin
            st_d.clock = st_q.clock + 1'b1;
            st_d.stamp[touch_set][touch_way] = st_q.clock + 1'b1;
            if (st_q.cnt[touch_set][touch_way] != CNT_MAX)
                st_d.cnt[touch_set][touch_way] = st_q.cnt[touch_set][touch_way] + 1'b1;
        end
        if (drop_en) begin
            st_d.cnt[drop_set][drop_way]   = '0;
            st_d.stamp[drop_set][drop_way] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_all   = st_q.cnt;
    assign stamp_all = st_q.stamp;

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && !drop_en && st_q.cnt[touch_set][touch_way] == CNT_MAX)
        |=> st_q.cnt[$past(touch_set)][$past(touch_way)] == CNT_MAX); // R4

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        drop_en |=> (st_q.cnt[$past(drop_set)][$past(drop_way)] == '0 &&
                     st_q.stamp[$past(drop_set)][$past(drop_way)] == '0)); // R8

    AST_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && !drop_en) |=> st_q.stamp[$past(touch_set)][$past(touch_way)] == st_q.clock); // R5

endmodule

// File: rtl/rvs_pick.sv
module rvs_pick #(
    parameter int NUM_WAYS = 4,
    parameter int KEY_W    = 16,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0][KEY_W-1:0] keys,
    output logic [WAY_W-1:0]               pick
);

    logic [KEY_W-1:0] best;

    always_comb begin
        best = keys[0];
        pick = '0;
        for (int i = 1; i < NUM_WAYS; i++) begin
            if (keys[i] < best) begin
                best = keys[i];
                pick = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
    parameter int NUM_SETS = 4,
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    parameter int STAMP_W  = 16,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_sel,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic             drop_en,
    input  logic [SET_W-1:0] drop_set,
    input  logic [WAY_W-1:0] drop_way,
    input  logic             ask_en,
    input  logic [SET_W-1:0] ask_set,
    output logic             victim_vld,
    output logic [WAY_W-1:0] victim_way
);

    import rvs_pkg::*;

    logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0]   cnt_all;
    logic [NUM_SETS-1:0][NUM_WAYS-1:0][STAMP_W-1:0] stamp_all;
    logic [15:0]      lfsr_val;
    logic [15:0]      rnd_mod;
    logic [WAY_W-1:0] lfu_pick, lru_pick, rnd_pick, pick;

    rvs_state #(
        .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .STAMP_W(STAMP_W)
    ) state_i (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
        .drop_en(drop_en), .drop_set(drop_set), .drop_way(drop_way),
        .cnt_all(cnt_all), .stamp_all(stamp_all)
    );

    rvs_lfsr #(.SEED(LFSR_SEED)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .value(lfsr_val)
    );

    rvs_pick #(.NUM_WAYS(NUM_WAYS), .KEY_W(CNT_W)) lfu_pick_i (
        .keys(cnt_all[ask_set]), .pick(lfu_pick)
    );

    rvs_pick #(.NUM_WAYS(NUM_WAYS), .KEY_W(STAMP_W)) lru_pick_i (
        .keys(stamp_all[ask_set]), .pick(lru_pick)
    );

    assign rnd_mod  = lfsr_val % 16'(NUM_WAYS);
    assign rnd_pick = rnd_mod[WAY_W-1:0];

    always_comb begin
        case (policy_e'(policy_sel))
            POL_LFU: pick = lfu_pick;
            POL_LRU: pick = lru_pick;
            default: pick = rnd_pick;
        endcase
    end

    typedef struct packed {
        logic             vld;
        logic [WAY_W-1:0] way;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = ask_en;
        if (ask_en) out_d.way = pick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign victim_vld = out_q.vld;
    assign victim_way = out_q.way;

    AST_ASK_TO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        ask_en |=> victim_vld); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ask_en |=> (!victim_vld && $stable(victim_way))); // R2

    AST_WAY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        victim_vld |-> (int'(victim_way) < NUM_WAYS)); // R6

endmodule

// File: tb/repl_victim_sel_tb.sv
module repl_victim_sel_tb_top;

    localparam int SETS = 4;
    localparam int WAYS = 4;
    localparam int CW   = 3;
    localparam int SW   = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] policy_sel = 2'b00;
    logic       touch_en = 1'b0, drop_en = 1'b0, ask_en = 1'b0;
    logic [1:0] touch_set = '0, drop_set = '0, ask_set = '0;
    logic [1:0] touch_way = '0, drop_way = '0;
    logic       victim_vld;
    logic [1:0] victim_way;

    int n_chk = 0;
    int n_fail = 0;

    int mdl_cnt [SETS][WAYS];
    int mdl_stamp [SETS][WAYS];
    int mdl_clock = 0;
    logic [15:0] mdl_lfsr;

    always #10 clk = ~clk;

    repl_victim_sel #(.NUM_SETS(SETS), .NUM_WAYS(WAYS), .CNT_W(CW), .STAMP_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
        .touch_en(touch_en), .touch_set(touch_set), .touch_way(touch_way),
        .drop_en(drop_en), .drop_set(drop_set), .drop_way(drop_way),
        .ask_en(ask_en), .ask_set(ask_set),
        .victim_vld(victim_vld), .victim_way(victim_way)
    );

    // R7 model of the random source
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdl_lfsr <= 16'hACE1;
        else        mdl_lfsr <= {mdl_lfsr[14:0], mdl_lfsr[15] ^ mdl_lfsr[13] ^ mdl_lfsr[12] ^ mdl_lfsr[10]};
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic chk(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic touch(int s, int w);
        touch_en = 1'b1; touch_set = 2'(s); touch_way = 2'(w);
        cyc();
        touch_en = 1'b0;
        mdl_clock++;
        mdl_stamp[s][w] = mdl_clock;
        if (mdl_cnt[s][w] < (1 << CW) - 1) mdl_cnt[s][w]++;
    endtask

    task automatic drop(int s, int w);
        drop_en = 1'b1; drop_set = 2'(s); drop_way = 2'(w);
        cyc();
        drop_en = 1'b0;
        mdl_cnt[s][w] = 0;
        mdl_stamp[s][w] = 0;
    endtask

    task automatic clear_set(int s);
        for (int w = 0; w < WAYS; w++) drop(s, w);
    endtask

    function automatic int model_pick(int s);
        int best, idx;
        idx = 0;
        if (policy_sel == 2'b01) begin
            best = mdl_cnt[s][0];
            for (int i = 1; i < WAYS; i++) if (mdl_cnt[s][i] < best) begin best = mdl_cnt[s][i]; idx = i; end
        end else if (policy_sel == 2'b10) begin
            best = mdl_stamp[s][0];
            for (int i = 1; i < WAYS; i++) if (mdl_stamp[s][i] < best) begin best = mdl_stamp[s][i]; idx = i; end
        end else begin
            idx = int'(mdl_lfsr) % WAYS;
        end
        return idx;
    endfunction

    // Issue a request, check the result one cycle later against exp, then check R2 timing.
    task automatic ask(int s, string rq, int exp);
        int mexp;
        mexp = model_pick(s);
        ask_en = 1'b1; ask_set = 2'(s);
        cyc();
        ask_en = 1'b0;
        chk("R2 vld", int'(victim_vld), 1);
        chk(rq, int'(victim_way), exp);
        chk({rq, " model"}, int'(victim_way), mexp);
        cyc();
        chk("R2 drop", int'(victim_vld), 0);
        chk("R2 hold", int'(victim_way), exp);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin mdl_cnt[s][w] = 0; mdl_stamp[s][w] = 0; end
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 vld", int'(victim_vld), 0);
        chk("R1 way", int'(victim_way), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: zero state gives way 0 under both ordered policies
        for (int s = 0; s < SETS; s++) begin
            policy_sel = 2'b01; ask(s, "R1 lfu zero", 0);
            policy_sel = 2'b10; ask(s, "R1 lru zero", 0);
        end

        // R3 least-used sweep over every set and target way
        policy_sel = 2'b01;
        for (int s = 0; s < SETS; s++)
            for (int t = 0; t < WAYS; t++) begin
                clear_set(s);
                for (int w = 0; w < WAYS; w++) if (w != t) begin touch(s, w); touch(s, w); end
                touch(s, t);
                ask(s, "R3 lfu target", t);
            end
        // R6 equal counts -> lowest way
        clear_set(0);
        for (int w = 0; w < WAYS; w++) touch(0, w);
        ask(0, "R6 lfu tie", 0);
        // R6 tie among the last two ways
        clear_set(0);
        touch(0, 0); touch(0, 0); touch(0, 1); touch(0, 1); touch(0, 2); touch(0, 3);
        ask(0, "R6 lfu tie high", 2);

        // R4 saturation: way0 touched 9 times stays at 7, others at 6
        clear_set(1);
        for (int k = 0; k < 9; k++) touch(1, 0);
        for (int w = 1; w < WAYS; w++) for (int k = 0; k < 6; k++) touch(1, w);
        ask(1, "R4 saturate", 1);

        // R8 drop wins over a same-edge touch
        clear_set(2);
        for (int w = 0; w < WAYS; w++) begin touch(2, w); touch(2, w); end
        touch_en = 1'b1; touch_set = 2'd2; touch_way = 2'd0;
        drop_en = 1'b1; drop_set = 2'd2; drop_way = 2'd0;
        cyc();
        touch_en = 1'b0; drop_en = 1'b0;
        mdl_clock++;
        mdl_cnt[2][0] = 0; mdl_stamp[2][0] = 0;
        ask(2, "R8 drop priority", 0);
        // R8 drop of a busy way makes it the victim
        drop(2, 3);
        ask(2, "R8 drop lfu", 0);
        touch(2, 0);
        ask(2, "R8 drop lfu way3", 3);

        // R10 set independence
        for (int s = 0; s < SETS; s++) clear_set(s);
        touch(2, 0); touch(2, 0);
        ask(2, "R10 own set", 1);
        ask(3, "R10 other set", 0);

        // R5 oldest-mark sweep: target touched first
        policy_sel = 2'b10;
        for (int s = 0; s < SETS; s++)
            for (int t = 0; t < WAYS; t++) begin
                touch(s, t);
                for (int k = 1; k < WAYS; k++) touch(s, (t + k) % WAYS);
                ask(s, "R5 lru target", t);
            end
        // R5 retouching the oldest moves the victim on
        touch(0, 3);
        for (int w = 0; w < WAYS; w++) touch(0, w);
        touch(0, 0);
        ask(0, "R5 lru retouch", 1);
        // R6 / R8 two dropped ways tie at zero mark
        drop(1, 2); drop(1, 1);
        ask(1, "R6 lru tie dropped", 1);

        // R9 history kept under random policy, used under least-used
        clear_set(3);
        policy_sel = 2'b00;
        touch(3, 0); touch(3, 1); touch(3, 3);
        policy_sel = 2'b01;
        ask(3, "R9 switch lfu", 2);
        policy_sel = 2'b10;
        ask(3, "R9 switch lru", 2);

        // R7 random sequence with varied gaps under both random codes
        for (int k = 0; k < 24; k++) begin
            policy_sel = (k % 2 == 0) ? 2'b00 : 2'b11;
            ask(k % SETS, "R7 random", int'(mdl_lfsr) % WAYS);
            repeat (k % 3) cyc();
        end

        summary();
        $finish;
    end

endmodule